// File: doc/BRIEF.md
# Flash Command Mailbox Target

This block is the device-side end of a mailbox that a host uses to reach an on-chip flash image. The host sees sixteen data dwords, one command word and one status word on a plain dword-addressed register bus. It writes a command word with the request bit set. The block then runs a flash read, a flash write, an authenticate-and-swap update or a power cycle against an internal two-region flash array. When the command is finished, the block clears the request bit and posts a status word. The host polls the request bit to learn that the command is done.

The flash array has two equal regions, an active one and a non-active one. Each access to the array takes a fixed number of cycles. Reads always come from the active region and writes always go to the non-active region. The authenticate command checks a signature dword at the bottom of the non-active region. If the check passes, the two regions trade roles.

Top module: `flash_mailbox`

## Requirements
- R1: After reset, the command word, the status word and every data dword read as zero, and `reset_req` is low.
- R2: The mailbox base is dword address `BASE` (0x3E). Data dword k (k = 1..16) sits at `BASE`+k, the command word at `BASE`+17 and the status word at `BASE`+18. A data dword written while idle reads back unchanged.
- R3: The command word has these fields: opcode [31:28], dword count [27:24], dword address [23:2], header flag [1] and request [0]. When a command finishes, only bit 0 is cleared; the other bits read back as written.
- R4: On completion the status word is: bit 29 = 1, [7:4] = opcode of the finished command, [3:0] = result code. The result codes are 0 = done, 1 = authentication failed, 2 = access error. All other bits are 0.
- R5: Opcode 0x2 (read) copies N dwords, starting at the given dword address of the active region, into data dwords 1..N. A count field of 0 means N = 16; any other value means N = count.
- R6: Opcode 0x0 (write) stores data dwords 1..N at the given address of the non-active region, with N = count + 1. The active region is left unchanged.
- R7: A write with header flag = 1 stores at dword address `HDR_DW` (48) of the non-active region, whatever its address field holds.
- R8: Opcode 0x1 (authenticate) succeeds when dword 0 of the non-active region equals `SIG`. On success the regions swap and the result code is 0. On failure the result code is 1 and the regions do not swap.
- R9: A read or write whose start address + N exceeds `REGION_DW` (64) completes with code 2 and changes neither the flash nor the data dwords. An undefined opcode (any value other than 0, 1, 2 or 4) also completes with code 2.
- R10: While the request bit is still set, bus writes to the command word and to the data dwords are ignored.
- R11: Opcode 0x4 (power cycle) completes with code 0. `reset_req` is high for exactly one cycle: the first cycle in which the request bit reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 8 | Dword register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| reset_req | output | 1 | One-cycle power-cycle request |

## Verification
The assertions check these rules on every cycle:
- The command word stays frozen while a command runs and is not yet finishing.
- Every fall of the request bit comes with a valid status flag.
- The region swap happens only on a successful authenticate.
- A write never moves the active region.
- `reset_req` is a single pulse that coincides with a finished power cycle.

Only the bench scenarios can show the data itself. These cover:
- Which region a read or write reaches.
- The count encodings, including 16 encoded as 0.
- The fixed header address.
- The address-range boundary, where start + N equal to 64 passes and 66 fails.
- That data dwords survive a failed command.

// File: rtl/flash_mailbox.sv
module flash_mailbox #(
  parameter logic [7:0]  BASE      = 8'h3E,
  parameter int          REGION_DW = 64,
  parameter int          LAT       = 3,
  parameter int          HDR_DW    = 48,
  parameter logic [31:0] SIG       = 32'h5AFE_C0DE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wen,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        reset_req
);

  localparam int AW = $clog2(REGION_DW);
  localparam int LW = $clog2(LAT + 1);
  localparam int MW = 2 * REGION_DW;
  localparam logic [3:0] OP_WR = 4'h0, OP_AUTH = 4'h1, OP_RD = 4'h2, OP_PWR = 4'h4;

  logic [31:0]   data_q [16];
  logic [31:0]   mem    [MW];
  logic [31:0]   cmd_q, stat_q;
  logic          act, rst_q, err_q;
  logic [3:0]    op_q;
  logic [4:0]    n_q, idx_q;
  logic [AW-1:0] base_q;
  logic [LW-1:0] lat_q;

  wire       busy     = cmd_q[0];
  wire [7:0] rel      = bus_addr - BASE;
  wire       hit_data = (rel >= 8'd1) && (rel <= 8'd16);
  wire       hit_cmd  = rel == 8'd17;
  wire       hit_stat = rel == 8'd18;
  wire [3:0] dsel     = 4'(rel - 8'd1);

  wire [3:0]  w_op  = bus_wdata[31:28];
  wire [3:0]  w_cnt = bus_wdata[27:24];
  wire        w_hdr = bus_wdata[1];
  wire [4:0]  w_n   = (w_op == OP_RD) ? ((w_cnt == 4'd0) ? 5'd16 : {1'b0, w_cnt})
                                      : {1'b0, w_cnt} + 5'd1;
  wire [22:0] w_start = (w_op == OP_WR && w_hdr) ? 23'(HDR_DW) : {1'b0, bus_wdata[23:2]};
  wire        w_mem   = (w_op == OP_WR) || (w_op == OP_RD);
  wire        w_range = (w_start + 23'(w_n)) > 23'(REGION_DW);
  wire        w_err   = w_mem ? w_range : !((w_op == OP_AUTH) || (w_op == OP_PWR));

  wire          step    = busy && (lat_q == LW'(LAT - 1));
  wire          xfer    = step && !err_q && ((op_q == OP_RD) || (op_q == OP_WR));
  wire          last    = !xfer || (idx_q == n_q - 5'd1);
  wire          fin     = step && last;
  wire [AW-1:0] faddr   = base_q + AW'(idx_q);
  wire [AW:0]   fa_act  = {act, faddr};
  wire [AW:0]   fa_non  = {~act, faddr};
  wire          auth_ok = mem[{~act, AW'(0)}] == SIG;
  wire [3:0]    code    = err_q ? 4'd2 : ((op_q == OP_AUTH) && !auth_ok) ? 4'd1 : 4'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      stat_q <= '0;
      act    <= 1'b0;
      rst_q  <= 1'b0;
      err_q  <= 1'b0;
      op_q   <= '0;
      n_q    <= '0;
      idx_q  <= '0;
      base_q <= '0;
      lat_q  <= '0;
      for (int i = 0; i < 16; i++) data_q[i] <= '0;
      for (int i = 0; i < MW; i++) mem[i] <= '0;
    end else begin
      rst_q <= fin && (op_q == OP_PWR);
      if (!busy) begin
        if (bus_wen && hit_data) data_q[dsel] <= bus_wdata;
        if (bus_wen && hit_cmd) begin
          cmd_q  <= bus_wdata;
          op_q   <= w_op;
          n_q    <= w_n;
          base_q <= w_start[AW-1:0];
          err_q  <= w_err;
          idx_q  <= '0;
          lat_q  <= '0;
        end
      end else begin
        lat_q <= step ? '0 : lat_q + 1'b1;
        if (xfer) begin
          if (op_q == OP_RD) data_q[idx_q[3:0]] <= mem[fa_act];
          else               mem[fa_non]        <= data_q[idx_q[3:0]];
          idx_q <= idx_q + 5'd1;
        end
        if (fin) begin
          cmd_q[0] <= 1'b0;
          stat_q   <= {2'b00, 1'b1, 21'd0, op_q, code};
          if ((op_q == OP_AUTH) && auth_ok) act <= ~act;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_data)      bus_rdata = data_q[dsel];
    else if (hit_cmd)  bus_rdata = cmd_q;
    else if (hit_stat) bus_rdata = stat_q;
  end

  assign reset_req = rst_q;

  p_cmd_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !fin |=> $stable(cmd_q));
  p_done_posts_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_q[0]) |-> stat_q[29]);
  p_swap_only_on_auth_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act != $past(act)) |-> (stat_q[7:0] == 8'h10));
  p_write_keeps_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (op_q == OP_WR) |=> (act == $past(act)));
  p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
  p_pulse_at_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> !cmd_q[0] && (stat_q[7:4] == OP_PWR));

endmodule

// File: tb/sim_flash_mailbox.sv
module sim_flash_mailbox;
  logic        clk = 1'b0, rst_n = 1'b0, bus_wen = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  wire         reset_req;

  always #4 clk = ~clk;

  flash_mailbox u0 (.clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
                    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .reset_req(reset_req));

  localparam logic [31:0] SIG = 32'h5AFE_C0DE;
  localparam logic [7:0]  BA = 8'h3E, CMD = 8'h4F, STAT = 8'h50;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] exp_q[$], act_q[$];
  string tag_q[$];
  int pulses;
  bit at_done;

  function automatic logic [31:0] mk(input logic [3:0] op, input logic [3:0] cnt,
                                     input logic [21:0] a, input bit hdr);
    return {op, cnt, a, hdr, 1'b1};
  endfunction

  task automatic push(input logic [31:0] a, input logic [31:0] e, input string t);
    act_q.push_back(a); exp_q.push_back(e); tag_q.push_back(t);
  endtask

  always @(posedge clk) begin
    while (act_q.size() > 0) begin
      logic [31:0] a, e;
      string t;
      a = act_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      total++;
      if (a !== e) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", t, a, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk); bus_addr = a; #1;
    push(bus_rdata, e, t);
  endtask

  task automatic wait_done();
    bit ok;
    ok = 0; pulses = 0; at_done = 0;
    bus_addr = CMD; #1;
    for (int i = 0; i < 400; i++) begin
      if (reset_req) pulses++;
      if (!bus_rdata[0]) begin ok = 1; at_done = reset_req; break; end
      @(negedge clk); bus_addr = CMD; #1;
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      if (reset_req) pulses++;
    end
    push({31'd0, ok}, 32'd1, "R3 request bit cleared");
  endtask

  task automatic run(input logic [31:0] c);
    wr(CMD, c);
    wait_done();
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog R3 actual=hung expected=complete");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(CMD, 32'h0, "R1 command word");
    rd(STAT, 32'h0, "R1 status word");
    rd(BA + 8'd1, 32'h0, "R1 data dword 1");
    push({31'd0, reset_req}, 32'd0, "R1 reset_req low");
    // R2 data register map
    wr(BA + 8'd1, 32'h1111_0001);
    wr(BA + 8'd16, 32'h1111_0016);
    rd(BA + 8'd1, 32'h1111_0001, "R2 data dword 1");
    rd(BA + 8'd16, 32'h1111_0016, "R2 data dword 16");
    // R6 write 4 dwords to non-active address 5
    for (int k = 1; k <= 4; k++) wr(BA + 8'(k), 32'hA000_0000 + k);
    run(mk(4'h0, 4'd3, 22'd5, 1'b0));
    rd(STAT, 32'h2000_0000, "R4 write done status");
    rd(CMD, 32'h0300_0014, "R3 fields kept, request cleared");
    // R6 active region untouched
    run(mk(4'h2, 4'd4, 22'd5, 1'b0));
    rd(BA + 8'd1, 32'h0, "R6 active region not written");
    rd(BA + 8'd4, 32'h0, "R6 active region not written dword 4");
    rd(STAT, 32'h2000_0020, "R4 read done status");
    // R8 signature then authenticate
    wr(BA + 8'd1, SIG);
    run(mk(4'h0, 4'd0, 22'd0, 1'b0));
    run(mk(4'h1, 4'd0, 22'd0, 1'b0));
    rd(STAT, 32'h2000_0010, "R8 auth success status");
    // R5 full 16-dword read from swapped region
    run(mk(4'h2, 4'd0, 22'd0, 1'b0));
    rd(BA + 8'd1, SIG, "R5 count 16 dword 1");
    rd(BA + 8'd6, 32'hA000_0001, "R5 count 16 dword 6");
    rd(BA + 8'd9, 32'hA000_0004, "R5 count 16 dword 9");
    rd(BA + 8'd10, 32'h0, "R5 count 16 dword 10");
    // R8 failed auth: non-active region holds no signature
    run(mk(4'h1, 4'd0, 22'd0, 1'b0));
    rd(STAT, 32'h2000_0011, "R8 auth failure status");
    run(mk(4'h2, 4'd1, 22'd0, 1'b0));
    rd(BA + 8'd1, SIG, "R8 no swap after failure");
    // R7 header write lands at fixed address
    wr(BA + 8'd1, 32'hCAFE_0001);
    run(mk(4'h0, 4'd0, 22'd3, 1'b1));
    rd(CMD, 32'h0000_000E, "R7 header command readback");
    wr(BA + 8'd1, SIG);
    run(mk(4'h0, 4'd0, 22'd0, 1'b0));
    run(mk(4'h1, 4'd0, 22'd0, 1'b0));
    run(mk(4'h2, 4'd1, 22'd48, 1'b0));
    rd(BA + 8'd1, 32'hCAFE_0001, "R7 header at fixed address");
    run(mk(4'h2, 4'd1, 22'd3, 1'b0));
    rd(BA + 8'd1, 32'h0, "R7 field address not written");
    // R9 range and opcode errors
    wr(BA + 8'd1, 32'h0000_1234);
    run(mk(4'h2, 4'd4, 22'd62, 1'b0));
    rd(STAT, 32'h2000_0022, "R9 out of range read status");
    rd(BA + 8'd1, 32'h0000_1234, "R9 data kept after error");
    run(mk(4'h3, 4'd0, 22'd0, 1'b0));
    rd(STAT, 32'h2000_0032, "R9 undefined opcode status");
    run(mk(4'h2, 4'd4, 22'd60, 1'b0));
    rd(STAT, 32'h2000_0020, "R9 boundary read accepted");
    rd(BA + 8'd1, 32'h0, "R9 boundary read data");
    // R10 writes ignored while busy
    wr(CMD, mk(4'h2, 4'd0, 22'd0, 1'b0));
    wr(CMD, mk(4'h4, 4'd0, 22'd0, 1'b0));
    wr(BA + 8'd1, 32'hDEAD_BEEF);
    wait_done();
    push(pulses, 0, "R10 ignored power cycle gave no pulse");
    rd(CMD, 32'h2000_0000, "R10 command word unchanged");
    rd(BA + 8'd1, SIG, "R10 data write ignored");
    rd(STAT, 32'h2000_0020, "R10 status of original command");
    // R11 power cycle
    run(mk(4'h4, 4'd0, 22'd0, 1'b0));
    push(pulses, 1, "R11 one reset_req pulse");
    push({31'd0, at_done}, 32'd1, "R11 pulse aligned with completion");
    rd(STAT, 32'h2000_0040, "R11 power cycle status");
    repeat (3) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end
endmodule